// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind an 8-bit host register bus. All three counters advance on a shared count-enable tick. Each counter drives one timer output. A two-bit address selects one of the three counter ports or a write-only command port.

A command byte does one of three things:
- programs a counter's byte-access scheme and operating mode;
- freezes a counter's value for reading;
- issues a read-back that freezes count and/or status for any set of counters in one write.

Three operating behaviours are built: one-shot interrupt on terminal count, a periodic rate generator, and a square-wave generator. Counting is binary only. Mode codes other than the three supported ones leave the counter idle with its output high.

A host writes a command, then writes the count bytes. The count moves into the counting element on the next tick. From then on the host polls the counter through the latch, read-back and status features.

Top module: `pit_top`

## Requirements
- R1: Address 3 is the command port and addresses 0, 1 and 2 are counter ports. Command bits [7:6] name counter 0, 1 or 2, and the value 3 makes the byte a read-back. A programming command (bits [5:4] nonzero) stores bits [5:0] for that counter. It drives its output low when the mode field [3:1] is 000, and high otherwise. The reset state of every output is high.
- R2: Access field [5:4]: 01 moves the low byte only (high byte written as zero), 10 moves the high byte only (low byte written as zero), 11 moves the low byte then the high byte. Reads follow the same byte order.
- R3: A completed count write moves into the counting element on the first count-enable tick in a later cycle. A loaded count of 0 counts as 65536. The null-count flag is set by a programming command or a completed count write, and cleared by that transfer.
- R4: Mode 000: the output goes low on the command and on each completed count write. It goes high on the tick where the count steps from 1 to 0, and then stays high while the count keeps decrementing with wrap.
- R5: Mode 010, count N: the period is N ticks. The output is low only during the tick where the count equals 1, then the count reloads to N.
- R6: Mode 011, count N: the period is N ticks. The output is high for ceil(N/2) ticks and low for floor(N/2) ticks.
- R7: Access field 00 in a command latches the named counter's value while counting continues. The latch is released after it has been fully read: one read in access modes 01/10, two reads in mode 11. A further latch while one is held is ignored.
- R8: Read-back: bits 1, 2 and 3 select counters 0, 1 and 2. Bit 5 low latches the count and bit 4 low latches the status. The status byte is {output level, null flag, stored bits [5:0]}.
- R9: When status and count are both latched, the first read returns the status and the following reads return the count bytes.
- R10: With nothing latched, a counter read returns the live counting element.
- R11: The three counters run independently: programming one leaves the others' counts and outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Port select: 0-2 counters, 3 command |
| wrEn | input | 1 | Write strobe, one cycle per byte |
| rdEn | input | 1 | Read strobe; advances byte order and releases latches |
| wrData | input | 8 | Write byte |
| cntEn | input | 1 | Count-enable tick shared by all counters |
| rdData | output | 8 | Combinational read byte for the addressed counter |
| timerOut | output | 3 | Per-counter output level |

## Verification
The bench computes the expected output and count value as a function of the mode, the count and the ticks since transfer. It checks every tick of random rate and square-wave periods, with odd and even square-wave counts. The following faults each show as a mismatch:
- An off-by-one reload in either periodic mode.
- A square wave that splits odd counts the wrong way.
- Treating count 0 as zero, which would end mode 000 at once.
- A latch that tracks the live count or is re-taken by a second command.
- A read-back that returns count before status.
- A null flag that never clears.
The bench also checks that reprogramming two counters does not disturb the third counter's output.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int NUM_CH = 3;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_WORD  = 2'b11
  } pitAccess_t;

  // per-counter one-cycle strobes from bus decode to the counters
  typedef struct packed {
    logic [NUM_CH-1:0] ctrlWr;
    logic [NUM_CH-1:0] cntLatch;
    logic [NUM_CH-1:0] dataWr;
    logic [NUM_CH-1:0] dataRd;
    logic [NUM_CH-1:0] rbCount;
    logic [NUM_CH-1:0] rbStatus;
  } pitStrobe_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] addr,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:1] cmdHi,
  output pitStrobe_t stb
);
  logic cmdWr;
  assign cmdWr = wrEn && (addr == 2'd3);

  always_comb begin
    stb = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      stb.dataWr[i]   = wrEn && (addr == 2'(i));
      stb.dataRd[i]   = rdEn && (addr == 2'(i));
      stb.ctrlWr[i]   = cmdWr && (cmdHi[7:6] == 2'(i)) && (cmdHi[5:4] != 2'b00);
      stb.cntLatch[i] = cmdWr && (cmdHi[7:6] == 2'(i)) && (cmdHi[5:4] == 2'b00);
      stb.rbCount[i]  = cmdWr && (cmdHi[7:6] == 2'b11) && cmdHi[i+1] && !cmdHi[5];
      stb.rbStatus[i] = cmdWr && (cmdHi[7:6] == 2'b11) && cmdHi[i+1] && !cmdHi[4];
    end
  end

  // R1
  single_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.dataWr | stb.ctrlWr | stb.cntLatch));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              ctrlWr,
  input  logic              cntLatch,
  input  logic              dataWr,
  input  logic              dataRd,
  input  logic              rbCount,
  input  logic              rbStatus,
  input  logic [BYTE_W-1:0] wData,
  output logic [BYTE_W-1:0] rdByte,
  output logic              outQ
);
  localparam int HALF = CNT_W / 2;

  logic [5:0]       ctrlBits;
  logic [CNT_W-1:0] countReg, reloadVal, ce, latchVal, nextCe, srcVal;
  logic             wrHi, rdHi, loadPending, nullFlag, armed;
  logic             cntLatched, statLatched;
  logic [7:0]       statVal;
  pitAccess_t       access;
  logic             isM0, isRate, isSq, modeOk, wrDone, sqOut;
  logic [CNT_W:0]   effN;

  assign access = pitAccess_t'(ctrlBits[5:4]);
  assign isM0   = (ctrlBits[3:1] == 3'b000);
  assign isRate = (ctrlBits[2:1] == 2'b10);
  assign isSq   = (ctrlBits[2:1] == 2'b11);
  assign modeOk = isM0 || isRate || isSq;
  assign wrDone = dataWr && (access == ACC_LO || access == ACC_HI ||
                             (access == ACC_WORD && wrHi));

  // periodic modes reload on reaching 1; zero stands for the full range
  assign nextCe = ((ce == CNT_W'(1)) && !isM0) ? reloadVal : ce - CNT_W'(1);
  assign effN   = {reloadVal == '0, reloadVal};
  assign sqOut  = {nextCe == '0, nextCe} > (effN >> 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlBits <= '0; countReg <= '0; reloadVal <= '0; ce <= '0;
      latchVal <= '0; statVal <= '0;
      wrHi <= 1'b0; rdHi <= 1'b0; loadPending <= 1'b0; nullFlag <= 1'b0;
      armed <= 1'b0; cntLatched <= 1'b0; statLatched <= 1'b0; outQ <= 1'b1;
    end else if (ctrlWr) begin
      ctrlBits    <= wData[5:0];
      outQ        <= (wData[3:1] != 3'b000);
      wrHi        <= 1'b0;
      rdHi        <= 1'b0;
      cntLatched  <= 1'b0;
      statLatched <= 1'b0;
      armed       <= 1'b0;
      loadPending <= 1'b0;
      nullFlag    <= 1'b1;
    end else begin
      if (dataWr) begin
        case (access)
          ACC_LO:   countReg <= {{HALF{1'b0}}, wData};
          ACC_HI:   countReg <= {wData, {HALF{1'b0}}};
          ACC_WORD: begin
            if (wrHi) countReg[CNT_W-1:HALF] <= wData;
            else      countReg[HALF-1:0]     <= wData;
            wrHi <= !wrHi;
          end
          default: ;
        endcase
      end
      if (cntEn && loadPending && modeOk) begin
        ce          <= countReg;
        reloadVal   <= countReg;
        loadPending <= 1'b0;
        nullFlag    <= 1'b0;
        armed       <= 1'b1;
        if (!isM0) outQ <= 1'b1;
      end else if (cntEn && armed) begin
        ce <= nextCe;
        if (isM0) begin
          if (ce == CNT_W'(1)) outQ <= 1'b1;
        end else if (isRate) outQ <= (nextCe != CNT_W'(1));
        else                 outQ <= sqOut;
      end
      if (wrDone) begin
        loadPending <= 1'b1;
        nullFlag    <= 1'b1;
        if (isM0) outQ <= 1'b0;
      end
      if (dataRd) begin
        if (statLatched) statLatched <= 1'b0;
        else if (access == ACC_WORD && !rdHi) rdHi <= 1'b1;
        else begin
          rdHi       <= 1'b0;
          cntLatched <= 1'b0;
        end
      end
      if ((cntLatch || rbCount) && !cntLatched) begin
        latchVal   <= ce;
        cntLatched <= 1'b1;
      end
      if (rbStatus && !statLatched) begin
        statVal     <= {outQ, nullFlag, ctrlBits};
        statLatched <= 1'b1;
      end
    end
  end

  assign srcVal = cntLatched ? latchVal : ce;

  always_comb begin
    if (statLatched)                    rdByte = statVal;
    else if (access == ACC_HI)          rdByte = srcVal[CNT_W-1:HALF];
    else if (access == ACC_WORD && rdHi) rdByte = srcVal[CNT_W-1:HALF];
    else                                rdByte = srcVal[HALF-1:0];
  end

  // R5
  rate_low_at_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && isRate && !outQ) |-> (ce == CNT_W'(1)));
  // R3
  null_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && loadPending && modeOk && !ctrlWr && !wrDone) |=> !nullFlag);
  // R4
  m0_out_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (armed && isM0 && outQ && !ctrlWr && !wrDone) |=> outQ);
  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntLatched && !dataRd && !ctrlWr) |=> $stable(latchVal));
endmodule

// File: rtl/pit_top.sv
module pit_top
  import pit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              cntEn,
  output logic [BYTE_W-1:0] rdData,
  output logic [NUM_CH-1:0] timerOut
);
  pitStrobe_t        stb;
  logic [BYTE_W-1:0] chRd [NUM_CH];

  pit_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .wrEn  (wrEn),
    .rdEn  (rdEn),
    .cmdHi (wrData[7:1]),
    .stb   (stb)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    pit_channel u_ch (
      .clk      (clk),
      .rstN     (rstN),
      .cntEn    (cntEn),
      .ctrlWr   (stb.ctrlWr[g]),
      .cntLatch (stb.cntLatch[g]),
      .dataWr   (stb.dataWr[g]),
      .dataRd   (stb.dataRd[g]),
      .rbCount  (stb.rbCount[g]),
      .rbStatus (stb.rbStatus[g]),
      .wData    (wrData),
      .rdByte   (chRd[g]),
      .outQ     (timerOut[g])
    );
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CH; i++)
      if (addr == 2'(i)) rdData = chRd[i];
  end
endmodule

// File: tb/test_pit_top.sv
module test_pit_top;
  logic       clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, cntEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  wire  [7:0] rdData;
  wire  [2:0] timerOut;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pit_top i_pit_top (.clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
                     .wrData(wrData), .cntEn(cntEn), .rdData(rdData), .timerOut(timerOut));

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntEn = 1'b1;
      @(negedge clk); cntEn = 1'b0;
    end
  endtask

  task automatic rd16(input logic [1:0] a, output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a, hi); v = {hi, lo};
  endtask

  task automatic prog(input int ch, input int mode, input int n);
    wr(2'd3, {2'(ch), 2'b11, 3'(mode), 1'b0});
    wr(2'(ch), 8'(n));
    wr(2'(ch), 8'(n >> 8));
  endtask

  function automatic int effOf(input int n);
    return (n == 0) ? 65536 : n;
  endfunction

  function automatic logic expOut(input int mode, input int n, input int k);
    int e, c;
    e = effOf(n);
    if (mode == 0) return (k >= e);
    c = e - (k % e);
    if (mode == 2) return (c != 1);
    return (c > e / 2);
  endfunction

  function automatic logic [15:0] expCnt(input int mode, input int n, input int k);
    int e;
    e = effOf(n);
    if (mode == 0) return 16'(n - k);
    return 16'(e - (k % e));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all-R actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int n1, n2, span;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset outputs high; R8 status after reset
    #1 chk("R1 reset outputs", 32'(timerOut), 32'h7);
    wr(2'd3, 8'hE2); rd(2'd0, b);
    chk("R8 reset status ch0", 32'(b), 32'h80);

    // R1/R4 mode 0 on counter 0, count 5
    wr(2'd3, 8'h30);
    #1 chk("R1 mode0 command drives low", 32'(timerOut[0]), 32'h0);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    wr(2'd3, 8'hE2); rd(2'd0, b);
    chk("R3 null set before transfer", 32'(b), 32'h70);
    tick(1);
    wr(2'd3, 8'hE2); rd(2'd0, b);
    chk("R3 null cleared after transfer", 32'(b), 32'h30);
    rd16(2'd0, v);
    chk("R10 live count after transfer", 32'(v), 32'd5);
    for (int k = 1; k <= 7; k++) begin
      tick(1);
      #1 chk("R4 mode0 output", 32'(timerOut[0]), 32'(expOut(0, 5, k)));
    end
    rd16(2'd0, v);
    chk("R4 count wraps past zero", 32'(v), 32'(expCnt(0, 5, 7)));

    // R3 count 0 means 65536
    prog(0, 0, 0);
    tick(1);
    rd16(2'd0, v); chk("R3 zero count loads", 32'(v), 32'h0);
    tick(1);
    rd16(2'd0, v); chk("R3 zero count decrements to FFFF", 32'(v), 32'hFFFF);
    #1 chk("R3 zero count no early terminal", 32'(timerOut[0]), 32'h0);

    // R5/R6/R11 random periods, counters 1 and 2 together
    for (int it = 0; it < 4; it++) begin
      n1 = 2 + int'($urandom % 30);
      n2 = 2 + int'($urandom % 38);
      n2 = (n2 & ~1) | (it & 1);
      if (n2 < 2) n2 = 3;
      prog(1, 2, n1);
      prog(2, 3, n2);
      tick(1);
      span = 2 * ((n1 > n2) ? n1 : n2);
      for (int k = 0; k < span; k++) begin
        #1;
        chk("R5 rate output", 32'(timerOut[1]), 32'(expOut(2, n1, k)));
        chk("R6 square output", 32'(timerOut[2]), 32'(expOut(3, n2, k)));
        chk("R11 counter0 undisturbed", 32'(timerOut[0]), 32'h0);
        if (k == n1 / 2) begin
          rd16(2'd1, v);
          chk("R10 rate live count", 32'(v), 32'(expCnt(2, n1, k)));
        end
        tick(1);
      end
    end

    // R7 counter latch
    prog(1, 2, 1000);
    tick(11);
    wr(2'd3, 8'h40);
    tick(3);
    rd16(2'd1, v); chk("R7 latched value", 32'(v), 32'd990);
    rd16(2'd1, v); chk("R7 counting continued", 32'(v), 32'd987);
    wr(2'd3, 8'h40); tick(2);
    wr(2'd3, 8'h40); tick(2);
    rd16(2'd1, v); chk("R7 second latch ignored", 32'(v), 32'd987);
    rd16(2'd1, v); chk("R7 released after full read", 32'(v), 32'd983);

    // R2 single-byte access modes on counter 2
    wr(2'd3, 8'h94); wr(2'd2, 8'h20); tick(1);
    rd(2'd2, b); chk("R2 low-only load", 32'(b), 32'h20);
    tick(1);
    rd(2'd2, b); chk("R2 low-only count", 32'(b), 32'h1F);
    wr(2'd3, 8'hA4); wr(2'd2, 8'h01); tick(1);
    rd(2'd2, b); chk("R2 high-only load", 32'(b), 32'h01);
    tick(1);
    rd(2'd2, b); chk("R2 high-only count 255", 32'(b), 32'h00);

    // R8/R9 read-back of count and status on counters 1 and 2
    prog(1, 2, 100);
    tick(6);
    wr(2'd3, 8'hCC);
    tick(2);
    rd(2'd1, b); chk("R9 status first ch1", 32'(b), 32'hB4);
    rd16(2'd1, v); chk("R8 latched count ch1", 32'(v), 32'd95);
    rd(2'd2, b); chk("R9 status first ch2", 32'(b), 32'hA4);
    rd(2'd2, b); chk("R8 latched high byte ch2", 32'(b), 32'h00);
    rd16(2'd1, v); chk("R10 live after release", 32'(v), 32'd93);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule